// File: doc/BRIEF.md
# Core Module System Control Registers

This block is a bank of 32-bit system control registers for a processor core module. Software reaches it through a plain word-addressed register bus: a byte address, a write strobe, write data and a registered read-data return. It holds the oscillator settings, a control register, an unlock key, the SDRAM and init settings, two groups of flag bits, and a small interrupt mask for one software-raised interrupt. It also exposes a read-only window onto a memory-module identification byte table.

The control register drives three board-level outputs. The first is an LED. The second is a boot remap indication, which reports that flash sits at address zero. The third is a one-cycle board reset request. Both oscillator registers are protected by a 16-bit unlock key. The flag registers and the interrupt enables are changed through separate set and clear addresses, so software never has to read, modify and write them back. Offsets that have no storage read as zero, and writes to them do nothing.

Every write takes effect on the clock edge where `reg_wr` is high. Every read returns its data one clock after the address is presented. The read data always reflects the register state from before any write in that same cycle. The register bus is a control path and not a data stream, so it has no valid/ready handshake and never applies back-pressure. Every access completes in the cycle it is issued.

Top module: `cm_ctrl_regs`

## Requirements
- R1: `reg_rdata` presents, one clock after `reg_addr` is applied, the value selected by the word offset (`reg_addr >> 2`). Word 0 reads the constant 0x411A3001, word 1 reads 0, and word 4 reads the constant 0x00100000.
- R2: A write to word 5 (key register) stores only bits [15:0] of the data. Word 5 reads back 0x0001A05F when the stored key equals 0xA05F, and reads the plain 16-bit stored value otherwise.
- R3: Writes to word 2 (main oscillator) and word 7 (auxiliary oscillator) update those registers only while the stored key equals 0xA05F. Otherwise the write is dropped.
- R4: Word 12 reads the flag register. A write to word 12 ORs the data into it, and a write to word 13 clears the bits that are set in the data. Words 14 and 15 do the same for the non-volatile flag register, which reads at word 14.
- R5: After reset, the registers hold these values: main oscillator 0x01000048, auxiliary oscillator 0x0007FEFF, init (word 9) 0x00000112, key 0, control 0, flags 0 and interrupt state 0. The SDRAM register (word 8) holds 0x00011122 ORed with a size code in bits [4:2]: 0x10 for a size of 256 MB or more, 0x0C for 128 MB or more, 0x08 for 64 MB or more, 0x04 for 32 MB or more, and 0 below that. The default of 128 MB gives 0x0001112E. Words 8 and 9 are plainly writable.
- R6: Byte addresses 0x100 to 0x17F read the identification table entry at index (addr − 0x100) >> 2, zero-extended. Entry 0 is 0x80, entry 2 is 0x04, and entry 31 is the module density (0x20 for 128 MB). Byte addresses 0x180 to 0x1FF read 0.
- R7: A write to word 3 (control) stores the data with bit 3 cleared. When the written bit 3 is 1, `board_rst_req` is high for exactly the following cycle. `led_on` follows stored bit 0. `flash_at_zero` is high while stored bit 2 is clear, which includes the state after reset.
- R8: The soft interrupt level uses data bit 0 only. A write with bit 0 set to word 20 raises it, and a write with bit 0 set to word 21 clears it. Word 20 reads the level in bit 0.
- R9: The IRQ enable mask is set through word 18 and cleared through word 19, and reads at word 18. The FIQ enable mask works the same way at words 26 and 27, and reads at word 26. Words 16 and 24 read the level ANDed with each mask, and words 17 and 25 read the raw level. `irq_req` and `fiq_req` are high whenever the level ANDed with the matching mask is non-zero.
- R10: Writes to read-only or unused offsets change no register, and reads of unused offsets, such as words 10 and 32, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W (9) | Byte address within the block |
| reg_wr | input | 1 | Write strobe for the current cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered, one cycle after the address |
| led_on | output | 1 | LED drive from control bit 0 |
| flash_at_zero | output | 1 | High while flash is mapped at address zero |
| board_rst_req | output | 1 | One-cycle board reset request |
| irq_req | output | 1 | Level ANDed with the IRQ mask is non-zero |
| fiq_req | output | 1 | Level ANDed with the FIQ mask is non-zero |

## Verification
A write is visible one clock after its strobe. The register outputs `led_on`, `flash_at_zero`, `board_rst_req` and the stored values all change on that edge. `irq_req` and `fiq_req` follow combinationally from the registered level and masks, so they also settle one clock after the write. Read data lands one clock after the address. The bench therefore drives each operation on a falling edge and samples on the next falling edge, after exactly one rising edge. The reset-request pulse is additionally checked to have dropped one further cycle later.

// File: rtl/cm_regs_pkg.sv
package cm_regs_pkg;
  localparam int DW = 32;

  // word offsets (byte address >> 2)
  localparam int W_ID       = 0;
  localparam int W_PROC     = 1;
  localparam int W_OSC      = 2;
  localparam int W_CTRL     = 3;
  localparam int W_STAT     = 4;
  localparam int W_KEY      = 5;
  localparam int W_AUXOSC   = 7;
  localparam int W_SDRAM    = 8;
  localparam int W_INIT     = 9;
  localparam int W_FLAG_SET = 12;
  localparam int W_FLAG_CLR = 13;
  localparam int W_NVF_SET  = 14;
  localparam int W_NVF_CLR  = 15;
  localparam int W_IRQ_STAT = 16;
  localparam int W_IRQ_RAW  = 17;
  localparam int W_IRQ_ESET = 18;
  localparam int W_IRQ_ECLR = 19;
  localparam int W_SOFT_SET = 20;
  localparam int W_SOFT_CLR = 21;
  localparam int W_FIQ_STAT = 24;
  localparam int W_FIQ_RAW  = 25;
  localparam int W_FIQ_ESET = 26;
  localparam int W_FIQ_ECLR = 27;

  localparam logic [DW-1:0] ID_VALUE     = 32'h411A_3001;
  localparam logic [DW-1:0] STAT_VALUE   = 32'h0010_0000;
  localparam logic [15:0]   UNLOCK_KEY   = 16'hA05F;
  localparam logic [DW-1:0] KEY_OPEN_RD  = 32'h0001_A05F;
  localparam logic [DW-1:0] OSC_RST      = 32'h0100_0048;
  localparam logic [DW-1:0] AUXOSC_RST   = 32'h0007_FEFF;
  localparam logic [DW-1:0] SDRAM_BASE   = 32'h0001_1122;
  localparam logic [DW-1:0] INIT_RST     = 32'h0000_0112;
  localparam int            CTRL_RST_BIT = 3;

  function automatic logic [DW-1:0] sdram_size_code(input int mb);
    if (mb >= 256)      return 32'h10;
    else if (mb >= 128) return 32'h0C;
    else if (mb >= 64)  return 32'h08;
    else if (mb >= 32)  return 32'h04;
    else                return 32'h00;
  endfunction

  function automatic logic [7:0] module_density(input int mb);
    if (mb >= 256)      return 8'd64;
    else if (mb >= 128) return 8'd32;
    else if (mb >= 64)  return 8'd16;
    else if (mb >= 32)  return 8'd4;
    else                return 8'd2;
  endfunction

  function automatic logic [7:0] id_byte(input int idx, input int mb);
    case (idx)
      0:  return 8'd128;
      1:  return 8'd8;
      2:  return 8'd4;
      3:  return 8'd11;
      4:  return 8'd9;
      5:  return 8'd1;
      6:  return 8'd64;
      8:  return 8'd2;
      9:  return 8'hA0;
      10: return 8'hA0;
      13: return 8'd8;
      15: return 8'd1;
      16: return 8'h0E;
      17: return 8'h04;
      18: return 8'h1C;
      19: return 8'h01;
      20: return 8'h02;
      21: return 8'h20;
      22: return 8'hC0;
      27: return 8'h30;
      28: return 8'h28;
      29: return 8'h30;
      30: return 8'h28;
      31: return module_density(mb);
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cm_id_window.sv
module cm_id_window #(
  parameter int MEM_MB  = 128,
  parameter int TABLE_N = 32,
  localparam int IDX_W  = $clog2(TABLE_N)
) (
  input  logic [IDX_W-1:0]          idx,
  input  logic                      in_table,
  output logic [cm_regs_pkg::DW-1:0] rd_val
);
  logic [7:0] tbl [TABLE_N];

  for (genvar i = 0; i < TABLE_N; i++) begin : g_tbl
    assign tbl[i] = cm_regs_pkg::id_byte(i, MEM_MB);
  end

  always_comb begin
    rd_val = '0;
    if (in_table) rd_val[7:0] = tbl[idx];
  end
endmodule

// File: rtl/cm_soft_int.sv
module cm_soft_int #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] wdata,
  input  logic          lvl_set,
  input  logic          lvl_clr,
  input  logic          irq_set,
  input  logic          irq_clr,
  input  logic          fiq_set,
  input  logic          fiq_clr,
  output logic [DW-1:0] level,
  output logic [DW-1:0] irq_mask,
  output logic [DW-1:0] fiq_mask,
  output logic          irq_req,
  output logic          fiq_req
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q    <= 1'b0;
      irq_mask <= '0;
      fiq_mask <= '0;
    end else begin
      if (lvl_set && wdata[0])      lvl_q <= 1'b1;
      else if (lvl_clr && wdata[0]) lvl_q <= 1'b0;
      if (irq_set)      irq_mask <= irq_mask | wdata;
      else if (irq_clr) irq_mask <= irq_mask & ~wdata;
      if (fiq_set)      fiq_mask <= fiq_mask | wdata;
      else if (fiq_clr) fiq_mask <= fiq_mask & ~wdata;
    end
  end

  assign level   = {{(DW-1){1'b0}}, lvl_q};
  assign irq_req = |(level & irq_mask);
  assign fiq_req = |(level & fiq_mask);
endmodule

// File: rtl/cm_ctrl_regs.sv
module cm_ctrl_regs #(
  parameter int ADDR_W  = 9,
  parameter int MEM_MB  = 128,
  parameter int TABLE_N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              led_on,
  output logic              flash_at_zero,
  output logic              board_rst_req,
  output logic              irq_req,
  output logic              fiq_req
);
  import cm_regs_pkg::*;

  localparam int WW    = ADDR_W - 3;
  localparam int IDX_W = $clog2(TABLE_N);
  localparam logic [DW-1:0] SDRAM_RST = SDRAM_BASE | sdram_size_code(MEM_MB);

  logic [WW-1:0] word;
  logic          in_window, win_lower, wr_reg;
  logic          addr_lsb_unused;

  assign word            = reg_addr[ADDR_W-2:2];
  assign in_window       = reg_addr[ADDR_W-1];
  assign win_lower       = in_window && !reg_addr[ADDR_W-2];
  assign wr_reg          = reg_wr && !in_window;
  assign addr_lsb_unused = ^reg_addr[1:0];

  function automatic logic hit(input logic [WW-1:0] w, input int off);
    return w == WW'(off);
  endfunction

  logic [DW-1:0] osc_q, aux_q, sdram_q, init_q, ctrl_q, flags_q, nvf_q;
  logic [15:0]   lock_q;
  logic          unlocked;

  assign unlocked = (lock_q == UNLOCK_KEY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      osc_q         <= OSC_RST;
      aux_q         <= AUXOSC_RST;
      sdram_q       <= SDRAM_RST;
      init_q        <= INIT_RST;
      ctrl_q        <= '0;
      flags_q       <= '0;
      nvf_q         <= '0;
      lock_q        <= '0;
      board_rst_req <= 1'b0;
    end else begin
      board_rst_req <= wr_reg && hit(word, W_CTRL) && reg_wdata[CTRL_RST_BIT];
      if (wr_reg) begin
        if (hit(word, W_OSC) && unlocked)    osc_q   <= reg_wdata;
        if (hit(word, W_AUXOSC) && unlocked) aux_q   <= reg_wdata;
        if (hit(word, W_KEY))                lock_q  <= reg_wdata[15:0];
        if (hit(word, W_SDRAM))              sdram_q <= reg_wdata;
        if (hit(word, W_INIT))               init_q  <= reg_wdata;
        if (hit(word, W_CTRL)) begin
          ctrl_q               <= reg_wdata;
          ctrl_q[CTRL_RST_BIT] <= 1'b0;
        end
        if (hit(word, W_FLAG_SET)) flags_q <= flags_q | reg_wdata;
        if (hit(word, W_FLAG_CLR)) flags_q <= flags_q & ~reg_wdata;
        if (hit(word, W_NVF_SET))  nvf_q   <= nvf_q | reg_wdata;
        if (hit(word, W_NVF_CLR))  nvf_q   <= nvf_q & ~reg_wdata;
      end
    end
  end

  assign led_on        = ctrl_q[0];
  assign flash_at_zero = !ctrl_q[2];

  logic [DW-1:0] level, irq_mask, fiq_mask;

  cm_soft_int #(.DW(DW)) u_int (
    .clk      (clk),
    .rst_n    (rst_n),
    .wdata    (reg_wdata),
    .lvl_set  (wr_reg && hit(word, W_SOFT_SET)),
    .lvl_clr  (wr_reg && hit(word, W_SOFT_CLR)),
    .irq_set  (wr_reg && hit(word, W_IRQ_ESET)),
    .irq_clr  (wr_reg && hit(word, W_IRQ_ECLR)),
    .fiq_set  (wr_reg && hit(word, W_FIQ_ESET)),
    .fiq_clr  (wr_reg && hit(word, W_FIQ_ECLR)),
    .level    (level),
    .irq_mask (irq_mask),
    .fiq_mask (fiq_mask),
    .irq_req  (irq_req),
    .fiq_req  (fiq_req)
  );

  logic [DW-1:0] win_val;

  cm_id_window #(.MEM_MB(MEM_MB), .TABLE_N(TABLE_N)) u_win (
    .idx      (reg_addr[IDX_W+1:2]),
    .in_table (win_lower),
    .rd_val   (win_val)
  );

  logic [DW-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (in_window) begin
      rd_next = win_val;
    end else begin
      case (word)
        WW'(W_ID):       rd_next = ID_VALUE;
        WW'(W_OSC):      rd_next = osc_q;
        WW'(W_CTRL):     rd_next = ctrl_q;
        WW'(W_STAT):     rd_next = STAT_VALUE;
        WW'(W_KEY):      rd_next = unlocked ? KEY_OPEN_RD : {16'b0, lock_q};
        WW'(W_AUXOSC):   rd_next = aux_q;
        WW'(W_SDRAM):    rd_next = sdram_q;
        WW'(W_INIT):     rd_next = init_q;
        WW'(W_FLAG_SET): rd_next = flags_q;
        WW'(W_NVF_SET):  rd_next = nvf_q;
        WW'(W_IRQ_STAT): rd_next = level & irq_mask;
        WW'(W_IRQ_RAW):  rd_next = level;
        WW'(W_IRQ_ESET): rd_next = irq_mask;
        WW'(W_SOFT_SET): rd_next = level;
        WW'(W_FIQ_STAT): rd_next = level & fiq_mask;
        WW'(W_FIQ_RAW):  rd_next = level;
        WW'(W_FIQ_ESET): rd_next = fiq_mask;
        default:         rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_next;
  end
endmodule

// File: rtl/cm_ctrl_regs_chk.sv
module cm_ctrl_regs_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       osc_q,
  input logic [31:0]       aux_q,
  input logic [15:0]       lock_q,
  input logic [31:0]       flags_q,
  input logic              board_rst_req,
  input logic              flash_at_zero,
  input logic              irq_req
);
  logic [ADDR_W-4:0] w;
  logic              regw, locked;
  assign w      = reg_addr[ADDR_W-2:2];
  assign regw   = reg_wr && !reg_addr[ADDR_W-1];
  assign locked = (lock_q != 16'hA05F);

  // R3: oscillator writes dropped while locked
  a_r3_osc_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (regw && w == 6'd2 && locked) |=> $stable(osc_q));
  a_r3_aux_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (regw && w == 6'd7 && locked) |=> $stable(aux_q));

  // R2: key keeps the low 16 bits
  a_r2_key_low: assert property (@(posedge clk) disable iff (!rst_n)
    (regw && w == 6'd5) |=> (lock_q == $past(reg_wdata[15:0])));

  // R4: set address only adds bits
  a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (regw && w == 6'd12) |=> ((flags_q & $past(reg_wdata)) == $past(reg_wdata)));

  // R7: reset request follows a control write with bit 3
  a_r7_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (regw && w == 6'd3 && reg_wdata[3]) |=> board_rst_req);
  a_r7_rst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(regw && w == 6'd3 && reg_wdata[3]) |=> !board_rst_req);
  a_r7_remap: assert property (@(posedge clk) disable iff (!rst_n)
    (regw && w == 6'd3) |=> (flash_at_zero == !$past(reg_wdata[2])));

  // R9: clearing all IRQ enables silences the request
  a_r9_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
    (regw && w == 6'd19 && reg_wdata == 32'hFFFF_FFFF) |=> !irq_req);
endmodule

bind cm_ctrl_regs cm_ctrl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_addr      (reg_addr),
  .reg_wr        (reg_wr),
  .reg_wdata     (reg_wdata),
  .osc_q         (osc_q),
  .aux_q         (aux_q),
  .lock_q        (lock_q),
  .flags_q       (flags_q),
  .board_rst_req (board_rst_req),
  .flash_at_zero (flash_at_zero),
  .irq_req       (irq_req)
);

// File: tb/cm_ctrl_regs_test.sv
module cm_ctrl_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        led_on, flash_at_zero, board_rst_req, irq_req, fiq_req;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cm_ctrl_regs uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .led_on(led_on),
    .flash_at_zero(flash_at_zero), .board_rst_req(board_rst_req),
    .irq_req(irq_req), .fiq_req(fiq_req)
  );

  // {write, byte address, write data or expected read}
  localparam int NV = 58;
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 9'h000, 32'h411A3001}, {1'b0, 9'h004, 32'h00000000},
    {1'b0, 9'h010, 32'h00100000}, {1'b0, 9'h008, 32'h01000048},
    {1'b0, 9'h01C, 32'h0007FEFF}, {1'b0, 9'h020, 32'h0001112E},
    {1'b0, 9'h024, 32'h00000112}, {1'b0, 9'h014, 32'h00000000},
    {1'b1, 9'h008, 32'h12345678}, {1'b0, 9'h008, 32'h01000048},
    {1'b1, 9'h014, 32'hFFFFA05F}, {1'b0, 9'h014, 32'h0001A05F},
    {1'b1, 9'h008, 32'h12345678}, {1'b0, 9'h008, 32'h12345678},
    {1'b1, 9'h01C, 32'h000000AA}, {1'b0, 9'h01C, 32'h000000AA},
    {1'b1, 9'h014, 32'h00000001}, {1'b0, 9'h014, 32'h00000001},
    {1'b1, 9'h008, 32'h00000000}, {1'b0, 9'h008, 32'h12345678},
    {1'b1, 9'h030, 32'h0000000F}, {1'b1, 9'h030, 32'h000000F0},
    {1'b0, 9'h030, 32'h000000FF}, {1'b1, 9'h034, 32'h0000003C},
    {1'b0, 9'h030, 32'h000000C3}, {1'b1, 9'h038, 32'h00000101},
    {1'b1, 9'h03C, 32'h00000001}, {1'b0, 9'h038, 32'h00000100},
    {1'b0, 9'h100, 32'h00000080}, {1'b0, 9'h108, 32'h00000004},
    {1'b0, 9'h17C, 32'h00000020}, {1'b0, 9'h180, 32'h00000000},
    {1'b0, 9'h1FC, 32'h00000000}, {1'b1, 9'h048, 32'h00000005},
    {1'b1, 9'h04C, 32'h00000004}, {1'b0, 9'h048, 32'h00000001},
    {1'b0, 9'h040, 32'h00000000}, {1'b1, 9'h050, 32'h00000003},
    {1'b0, 9'h044, 32'h00000001}, {1'b0, 9'h040, 32'h00000001},
    {1'b0, 9'h050, 32'h00000001}, {1'b0, 9'h060, 32'h00000000},
    {1'b1, 9'h068, 32'h00000003}, {1'b0, 9'h060, 32'h00000001},
    {1'b0, 9'h068, 32'h00000003}, {1'b1, 9'h06C, 32'h00000001},
    {1'b0, 9'h060, 32'h00000000}, {1'b1, 9'h054, 32'h00000001},
    {1'b0, 9'h044, 32'h00000000}, {1'b1, 9'h080, 32'hFFFFFFFF},
    {1'b0, 9'h080, 32'h00000000}, {1'b1, 9'h000, 32'hFFFFFFFF},
    {1'b0, 9'h000, 32'h411A3001}, {1'b0, 9'h028, 32'h00000000},
    {1'b1, 9'h020, 32'h00000055}, {1'b0, 9'h020, 32'h00000055},
    {1'b1, 9'h024, 32'h00000777}, {1'b0, 9'h024, 32'h00000777}
  };

  function automatic string req_of(input logic [8:0] a);
    if (a >= 9'h100) return "R6";
    case (a)
      9'h000, 9'h004, 9'h010: return "R1";
      9'h014:                 return "R2";
      9'h008, 9'h01C:         return "R3";
      9'h030, 9'h038:         return "R4";
      9'h020, 9'h024:         return "R5";
      9'h050:                 return "R8";
      9'h028, 9'h080:         return "R10";
      default:                return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7 / R9: outputs straight after reset
    check("R7", {29'b0, led_on, flash_at_zero, board_rst_req}, 32'h2);
    check("R9", {30'b0, irq_req, fiq_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][41]) wr(VEC[i][40:32], VEC[i][31:0]);
      else begin
        rd(VEC[i][40:32], r);
        check(req_of(VEC[i][40:32]), r, VEC[i][31:0]);
      end
    end

    // R7: control register, LED, remap and reset pulse
    wr(9'h00C, 32'h5);
    check("R7", {29'b0, led_on, flash_at_zero, board_rst_req}, 32'h4);
    rd(9'h00C, r);
    check("R7", r, 32'h5);
    wr(9'h00C, 32'hC);
    check("R7", {29'b0, led_on, flash_at_zero, board_rst_req}, 32'h1);
    @(negedge clk);
    check("R7", {31'b0, board_rst_req}, 32'h0);
    rd(9'h00C, r);
    check("R7", r, 32'h4);
    wr(9'h00C, 32'h0);
    check("R7", {29'b0, led_on, flash_at_zero, board_rst_req}, 32'h2);

    // R9: request outputs (IRQ mask bit0 set, FIQ mask holds bit1 only)
    wr(9'h050, 32'h1);
    check("R9", {30'b0, irq_req, fiq_req}, 32'h2);
    wr(9'h068, 32'h1);
    check("R9", {30'b0, irq_req, fiq_req}, 32'h3);
    wr(9'h04C, 32'hFFFFFFFF);
    check("R9", {30'b0, irq_req, fiq_req}, 32'h1);
    // R8: clear with bit0 zero has no effect, then a real clear
    wr(9'h054, 32'hFFFFFFFE);
    rd(9'h050, r);
    check("R8", r, 32'h1);
    wr(9'h054, 32'h1);
    check("R9", {30'b0, irq_req, fiq_req}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule